// File: doc/BRIEF.md
# Linked Dual Capture Counter

This block holds two 16-bit up-counters driven from one clock and one shared count enable. Each channel watches its own capture pin. When an enabled edge arrives, the channel copies its running count into a capture register. It can also be set up to zero its counter on that event. A global link bit ties the two channels together. While the bit is set, software that writes either counter loads both counters. A channel can also be made to follow the other: it zeroes in the same cycle that its partner zeroes on a capture.

All configuration arrives over a plain register write port. The word address selects the target:

| Address | Target |
|---|---|
| 0 | link register; bit 0 is the link bit |
| 1 | control register, channel 0 |
| 2 | control register, channel 1 |
| 3 | counter, channel 0 |
| 4 | counter, channel 1 |

Writes to addresses 5 to 7 are dropped. Each control byte has three fields:

| Bits | Field | Meaning |
|---|---|---|
| [2:0] | clear source | what zeroes the counter |
| [5:3] | pin function | whether the pin captures |
| [7:6] | edge select | which pin edges count |

The counters and capture registers are visible on the outputs at all times.

Top module: `sync_dual_timer`

## Requirements
- R1: After reset, both counters, both capture registers, the link bit and both control bytes are zero.
- R2: With `cnt_en_i` high and no higher-priority action, each counter increments by one per cycle and wraps from FFFFh to 0000h.
- R3: With the link bit at 0, a write to address 3 or 4 loads only the addressed counter, and the new value is seen on the next cycle.
- R4: With the link bit at 1, a write to address 3 or 4 loads the written value into both counters in the same cycle.
- R5: Each capture pin passes through two synchronizer flops. A capture occurs under two conditions: the pin-function field is 100b, and the edge-select field is 00b with a rising edge seen on the synchronized pin. On a capture, the capture register takes the counter value of that cycle.
- R6: Edge select 01b captures on falling edges, 10b captures on both edges and 11b never captures. A pin-function value other than 100b disables capture and leaves the capture register unchanged.
- R7: Clear-source 001b zeroes the channel's counter on its own capture. The capture register still receives the value from before the clear.
- R8: Clear-source 011b with the link bit at 1 zeroes the channel's counter in the cycle its partner clears on its own capture. This works in both directions.
- R9: With the link bit at 0, clear-source 011b has no effect. Clear-source codes other than 001b and 011b never clear.
- R10: A follow-clear propagates one level only. If both channels use 011b, a capture clears neither counter.
- R11: Within one cycle, a counter write wins over a clear, and a clear wins over an increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_en_i | input | 1 | Shared count enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register word address |
| wr_data_i | input | 16 | Write data |
| cap_pin_i | input | 2 | Capture pins, bit i belongs to channel i |
| cnt0_o | output | 16 | Channel 0 counter |
| cnt1_o | output | 16 | Channel 1 counter |
| cap0_o | output | 16 | Channel 0 capture register |
| cap1_o | output | 16 | Channel 1 capture register |

## Verification
The assertions take the capture pins to be quasi-static relative to the clock. They expect each pin level to last at least one cycle, so that the synchronizer never has to report two edges closer together than a clock period. They also take a counter write and a control write arriving in the same cycle to act on the control values held before that cycle. The stimulus drives every input away from the rising edge and holds each pin level for whole cycles. Its random phase writes control bytes with the pin function set to capture most of the time, so that the clear and follow-clear paths are reached often.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int CNT_W = 16;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_MODE  = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL0 = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT0  = 3'd3;

  localparam logic [2:0] CLR_NONE = 3'b000;
  localparam logic [2:0] CLR_OWN  = 3'b001;
  localparam logic [2:0] CLR_PEER = 3'b011;
  localparam logic [2:0] IO_CAPTURE = 3'b100;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'b00,
    EDGE_FALL = 2'b01,
    EDGE_BOTH = 2'b10,
    EDGE_OFF  = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e  edge_sel;
    logic [2:0] io_ctl;
    logic [2:0] clr_src;
  } ctrl_t;
endpackage

// File: rtl/sdt_cap_detect.sv
module sdt_cap_detect
  import sdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  edge_sel_e  edge_sel_i,
  input  logic [2:0] io_ctl_i,
  output logic       evt_o
);
  logic s1_q, s2_q, s3_q;
  logic rise, fall, hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
  assign fall = ~s2_q & s3_q;

  always_comb begin
    unique case (edge_sel_i)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end

  assign evt_o = hit && (io_ctl_i == IO_CAPTURE);

  AST_NO_EVT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_sel_i == EDGE_OFF) |-> !evt_o); // R6
endmodule

// File: rtl/sdt_channel.sv
module sdt_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             wr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic             clr_i,
  input  logic             cap_evt_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cap_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (wr_i)     cnt_q <= wr_data_i;
    else if (clr_i)    cnt_q <= '0;
    else if (cnt_en_i) cnt_q <= cnt_q + ONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cap_q <= '0;
    else if (cap_evt_i) cap_q <= cnt_q;
  end

  assign cnt_o = cnt_q;
  assign cap_o = cap_q;

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cnt_q == $past(wr_data_i)); // R11
  AST_CLEAR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !wr_i) |=> cnt_q == '0); // R7
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1 && cnt_en_i && !wr_i && !clr_i) |=> cnt_q == '0); // R2
  AST_CAP_VALUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_evt_i |=> cap_q == $past(cnt_q)); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cnt_en_i && !wr_i && !clr_i) |=> $stable(cnt_q)); // R2
endmodule

// File: rtl/sync_dual_timer.sv
module sync_dual_timer
  import sdt_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cnt_en_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [1:0]    cap_pin_i,
  output logic [W-1:0]  cnt0_o,
  output logic [W-1:0]  cnt1_o,
  output logic [W-1:0]  cap0_o,
  output logic [W-1:0]  cap1_o
);
  localparam int NCH = 2;
  localparam int CTRL_W = $bits(ctrl_t);

  logic           sync_q;
  ctrl_t          ctrl_q   [NCH];
  logic [NCH-1:0] evt, own_clr, peer_clr, wr_cnt;
  logic [W-1:0]   cnt      [NCH];
  logic [W-1:0]   cap      [NCH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 1'b0;
    else if (wr_en_i && wr_addr_i == AW'(ADDR_MODE)) sync_q <= wr_data_i[0];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int J = NCH - 1 - i;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ctrl_q[i] <= '0;
      else if (wr_en_i && wr_addr_i == AW'(ADDR_CTRL0 + i))
        ctrl_q[i] <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
    end

    sdt_cap_detect u_det (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .pin_i      (cap_pin_i[i]),
      .edge_sel_i (ctrl_q[i].edge_sel),
      .io_ctl_i   (ctrl_q[i].io_ctl),
      .evt_o      (evt[i])
    );

    assign own_clr[i] = evt[i] && (ctrl_q[i].clr_src == CLR_OWN);
    // follow only the partner's own clear: one level, no loop
    assign peer_clr[i] = sync_q && (ctrl_q[i].clr_src == CLR_PEER) && own_clr[J];
    assign wr_cnt[i] = wr_en_i && ((wr_addr_i == AW'(ADDR_CNT0 + i)) ||
                                   (sync_q && wr_addr_i == AW'(ADDR_CNT0 + J)));

    sdt_channel #(.CNT_W(W)) u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cnt_en_i  (cnt_en_i),
      .wr_i      (wr_cnt[i]),
      .wr_data_i (wr_data_i),
      .clr_i     (own_clr[i] | peer_clr[i]),
      .cap_evt_i (evt[i]),
      .cnt_o     (cnt[i]),
      .cap_o     (cap[i])
    );

    AST_CAP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[i].io_ctl != IO_CAPTURE) |=> $stable(cap[i])); // R6
    AST_PEER_FOLLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sync_q && ctrl_q[i].clr_src == CLR_PEER && own_clr[J] && !wr_cnt[i])
      |=> cnt[i] == '0); // R8
  end

  assign cnt0_o = cnt[0];
  assign cnt1_o = cnt[1];
  assign cap0_o = cap[0];
  assign cap1_o = cap[1];

  AST_SYNC_PRESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && wr_en_i && (wr_addr_i == AW'(ADDR_CNT0) || wr_addr_i == AW'(ADDR_CNT0 + 1)))
    |=> cnt[0] == cnt[1]); // R4
  AST_NO_LOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q[0].clr_src == CLR_PEER && ctrl_q[1].clr_src == CLR_PEER)
    |-> (own_clr == 2'b00)); // R10
endmodule

// File: tb/sync_dual_timer_bench.sv
`timescale 1ns/1ps
module sync_dual_timer_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cnt_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [1:0]  pin = '0;
  logic [15:0] cnt0, cnt1, cap0, cap1;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 0;
  bit    live = 0;
  string req = "R1";

  always #5 clk = ~clk;

  sync_dual_timer u_sync_dual_timer (
    .clk_i(clk), .rst_ni(rst_ni), .cnt_en_i(cnt_en), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .cap_pin_i(pin),
    .cnt0_o(cnt0), .cnt1_o(cnt1), .cap0_o(cap0), .cap1_o(cap1)
  );

  // behavioural reference
  logic [15:0] m_cnt [2];
  logic [15:0] m_cap [2];
  logic [7:0]  m_ctl [2];
  logic        m_sync;
  logic        h1 [2], h2 [2], h3 [2];

  always @(posedge clk) begin
    logic ev [2], oc [2], pc [2], wv [2];
    if (!rst_ni) begin
      m_sync = 0;
      for (int i = 0; i < 2; i++) begin
        m_cnt[i] = 0; m_cap[i] = 0; m_ctl[i] = 0;
        h1[i] = 0; h2[i] = 0; h3[i] = 0;
      end
    end else begin
      for (int i = 0; i < 2; i++) begin
        logic r, f;
        r = h2[i] && !h3[i];
        f = !h2[i] && h3[i];
        case (m_ctl[i][7:6])
          2'd0: ev[i] = r;
          2'd1: ev[i] = f;
          2'd2: ev[i] = r || f;
          default: ev[i] = 0;
        endcase
        if (m_ctl[i][5:3] != 3'd4) ev[i] = 0;
        oc[i] = ev[i] && m_ctl[i][2:0] == 3'd1;
      end
      for (int i = 0; i < 2; i++) begin
        pc[i] = m_sync && m_ctl[i][2:0] == 3'd3 && oc[1-i];
        wv[i] = wr_en && (int'(wr_addr) == 3 + i || (m_sync && int'(wr_addr) == 4 - i));
      end
      for (int i = 0; i < 2; i++) begin
        if (ev[i]) m_cap[i] = m_cnt[i];
        if (wv[i]) m_cnt[i] = wr_data;
        else if (oc[i] || pc[i]) m_cnt[i] = 0;
        else if (cnt_en) m_cnt[i] = m_cnt[i] + 16'd1;
        h3[i] = h2[i]; h2[i] = h1[i]; h1[i] = pin[i];
      end
      if (wr_en && wr_addr == 3'd0) m_sync = wr_data[0];
      if (wr_en && wr_addr == 3'd1) m_ctl[0] = wr_data[7:0];
      if (wr_en && wr_addr == 3'd2) m_ctl[1] = wr_data[7:0];
    end
  end

  task automatic chk(input string r, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && rst_ni && !done) begin
      chk(req, "cnt0", cnt0, m_cnt[0]);
      chk(req, "cnt1", cnt1, m_cnt[1]);
      chk(req, "cap0", cap0, m_cap[0]);
      chk(req, "cap1", cap1, m_cap[1]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 0;
  endtask

  task automatic edge_on(input int ch, input logic v);
    pin[ch] = v;
    cyc(5);
  endtask

  task automatic finish_run;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #1ms;
    n_err++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    cyc(3);
    chk("R1", "cnt0", cnt0, 16'h0); chk("R1", "cnt1", cnt1, 16'h0);
    chk("R1", "cap0", cap0, 16'h0); chk("R1", "cap1", cap1, 16'h0);
    rst_ni = 1; live = 1;
    cyc(1);

    req = "R3"; wr(3'd3, 16'h1234); cyc(1);
    chk("R3", "cnt0", cnt0, 16'h1234); chk("R3", "cnt1 untouched", cnt1, 16'h0);

    req = "R4"; wr(3'd0, 16'h1); wr(3'd4, 16'hABCD); cyc(1);
    chk("R4", "cnt0", cnt0, 16'hABCD); chk("R4", "cnt1", cnt1, 16'hABCD);

    req = "R2"; wr(3'd3, 16'hFFFE); cnt_en = 1; cyc(2); cnt_en = 0; cyc(1);
    chk("R2", "wrap cnt0", cnt0, 16'h0000); chk("R2", "wrap cnt1", cnt1, 16'h0000);

    req = "R11"; cnt_en = 1; wr(3'd3, 16'h0100); cnt_en = 0;
    chk("R11", "write over inc", cnt0, 16'h0100);

    req = "R5"; wr(3'd0, 16'h0); wr(3'd1, 16'h0020); wr(3'd3, 16'h0050);
    edge_on(0, 1);
    chk("R5", "cap0 rise", cap0, 16'h0050);

    req = "R6"; wr(3'd1, 16'h0060); wr(3'd3, 16'h0060); edge_on(0, 0);
    chk("R6", "cap0 fall", cap0, 16'h0060);
    wr(3'd1, 16'h0000); wr(3'd3, 16'h0077); edge_on(0, 1); edge_on(0, 0);
    chk("R6", "cap0 disabled", cap0, 16'h0060);
    wr(3'd1, 16'h00E0); edge_on(0, 1);
    chk("R6", "cap0 edge off", cap0, 16'h0060);
    edge_on(0, 0);

    req = "R7"; wr(3'd1, 16'h0021); wr(3'd3, 16'h0090); edge_on(0, 1);
    chk("R7", "cap0 pre-clear", cap0, 16'h0090); chk("R7", "cnt0 cleared", cnt0, 16'h0);
    edge_on(0, 0);

    req = "R8"; wr(3'd0, 16'h1); wr(3'd2, 16'h0003); wr(3'd3, 16'h0040); edge_on(0, 1);
    chk("R8", "cnt1 follows 0", cnt1, 16'h0);
    wr(3'd1, 16'h0003); wr(3'd2, 16'h0021); wr(3'd4, 16'h0041); edge_on(1, 1);
    chk("R8", "cnt0 follows 1", cnt0, 16'h0);
    edge_on(1, 0); edge_on(0, 0);

    req = "R9"; wr(3'd0, 16'h0); wr(3'd3, 16'h0042); wr(3'd4, 16'h0043); edge_on(1, 1);
    chk("R9", "cnt0 no follow", cnt0, 16'h0042); chk("R9", "cnt1 own", cnt1, 16'h0);
    edge_on(1, 0);
    wr(3'd2, 16'h0022); wr(3'd4, 16'h0044); edge_on(1, 1);
    chk("R9", "code 010 no clear", cnt1, 16'h0044);
    edge_on(1, 0);

    req = "R10"; wr(3'd0, 16'h1); wr(3'd1, 16'h0023); wr(3'd2, 16'h0023);
    wr(3'd3, 16'h0045); edge_on(0, 1);
    chk("R10", "cap0", cap0, 16'h0045);
    chk("R10", "cnt0 kept", cnt0, 16'h0045); chk("R10", "cnt1 kept", cnt1, 16'h0045);

    req = "R11";
    for (int k = 0; k < 4000; k++) begin
      int rv;
      rv = $urandom_range(0, 99);
      cnt_en = $urandom_range(0, 3) != 0;
      if ($urandom_range(0, 5) == 0) pin[$urandom_range(0, 1)] ^= 1'b1;
      wr_en = rv < 20;
      wr_addr = 3'($urandom_range(0, 7));
      wr_data = 16'($urandom);
      if (wr_addr == 3'd1 || wr_addr == 3'd2) begin
        if ($urandom_range(0, 3) != 0) wr_data[5:3] = 3'b100;
        if ($urandom_range(0, 1) != 0) wr_data[2:0] = ($urandom_range(0, 1) != 0) ? 3'b001 : 3'b011;
      end
      cyc(1);
    end
    wr_en = 0;
    cyc(2);
    finish_run();
  end
endmodule